// File: doc/BRIEF.md
# Dependence-Steered FIFO Issue Queue

This block is the issue stage of an out-of-order core built around a few short in-order FIFOs instead of one fully associative window. Each cycle at most one renamed instruction arrives with a destination tag and two source tags. The block steers it into a FIFO by dependence. If one of its operands is still being produced, it goes behind the FIFO whose youngest entry writes that operand. Otherwise it opens a fresh, empty FIFO. Chains of dependent work line up in order, and independent work spreads across the FIFOs.

Only the oldest entry of each FIFO competes for issue. A per-register ready table decides whether that entry's two operands exist. Up to an issue width of ready heads leave each cycle, lowest FIFO index first. Each of them marks its destination ready for the following cycle. An execution-side hold input can freeze issue for a cycle. The dispatch side sees a combinational stall whenever no suitable FIFO can take the offered instruction.

Top module: `dep_fifo_iq`

## Requirements
- R1: After reset every FIFO is empty, every register's ready bit is set, `in_stall` is low and no issue slot is valid.
- R2: An accepted instruction with at least one source whose ready bit is clear is appended to the lowest-indexed non-empty FIFO whose youngest (tail) entry has a destination equal to either source.
- R3: An entry that is in a FIFO but is not that FIFO's tail makes no FIFO eligible; without a tail match the instruction goes to the lowest-indexed empty FIFO.
- R4: An instruction whose two sources both have their ready bits set goes to the lowest-indexed empty FIFO, even when some FIFO's tail writes one of its sources.
- R5: Only the head entry of a FIFO can issue, and only when the ready bits of both its sources are set; the entries of one FIFO issue in arrival order.
- R6: Up to IW heads issue in one cycle, chosen by ascending FIFO index. Slot 0 carries the lowest chosen FIFO and `iss_fifo` gives each slot's FIFO index. Each issued entry leaves its FIFO, so the next entry becomes head in the following cycle.
- R7: An issued instruction sets the ready bit of its destination, and heads see it in the next cycle. An accepted instruction clears its destination's ready bit from the next cycle on. If both happen to one register in the same cycle, the clear wins.
- R8: With `in_valid` high, `in_stall` is high in the same cycle, and nothing is written, when the rule of R2 to R4 finds no FIFO (no empty FIFO where one is needed), or when the chosen FIFO already holds DEPTH entries.
- R9: While `iss_hold` is high no slot is valid and no FIFO loses an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A renamed instruction is offered this cycle |
| in_dst | input | RW | Destination register tag of the offered instruction |
| in_s0 | input | RW | First source register tag |
| in_s1 | input | RW | Second source register tag |
| iss_hold | input | 1 | Execution side cannot take instructions this cycle |
| in_stall | output | 1 | Offered instruction is refused this cycle |
| iss_vld | output | IW | Per-slot issue valid, filled from slot 0 upward |
| iss_dst | output | IW*RW | Per-slot destination tag, slot i at bits i*RW |
| iss_fifo | output | IW*QW | Per-slot source FIFO index, slot i at bits i*QW |

## Verification
The bench goes after the steering corners. An operand whose producer sits behind a younger entry must not attract the consumer. A design that compared every entry, or the head, would push it behind the wrong chain. An all-ready instruction offered while a tail matches must still open a fresh FIFO. When two tails match, the lower index must win. A burst of ready heads released after a hold must leave in ascending FIFO order and be capped at the issue width. A FIFO filled to its depth must refuse the next member of its chain. All FIFOs busy must refuse an independent instruction. A design that wrapped a pointer or dropped the refusal would lose or duplicate entries. The same-cycle ready visibility is also targeted. A consumer sent behind a producer that is issuing in that very cycle must wait one cycle, not issue early on a stale table.

// File: rtl/dep_fifo_iq.sv
module dep_fifo_iq #(
  parameter int NQ    = 4,
  parameter int DEPTH = 8,
  parameter int NREG  = 32,
  parameter int IW    = 2,
  localparam int RW   = $clog2(NREG),
  localparam int QW   = $clog2(NQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [RW-1:0]    in_dst,
  input  logic [RW-1:0]    in_s0,
  input  logic [RW-1:0]    in_s1,
  input  logic             iss_hold,
  output logic             in_stall,
  output logic [IW-1:0]    iss_vld,
  output logic [IW*RW-1:0] iss_dst,
  output logic [IW*QW-1:0] iss_fifo
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = 3 * RW;

  logic [EW-1:0]   mem [NQ][DEPTH];
  logic [PW-1:0]   hd  [NQ];
  logic [CW-1:0]   cnt [NQ];
  logic [EW-1:0]   head_e [NQ];
  logic [NREG-1:0] rdy, rdy_nxt;
  logic [NQ-1:0]   pop, busy, tail_hit, head_ok;
  logic [QW-1:0]   sel_q, emp_q, hit_q;
  logic            sel_ok, emp_ok, hit_ok, both_rdy, acc;
  logic [PW-1:0]   wp;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic [PW-1:0] tl;
    logic [EW-1:0] te;
    assign tl          = hd[q] + PW'(cnt[q]) - PW'(1);
    assign te          = mem[q][tl];
    assign head_e[q]   = mem[q][hd[q]];
    assign busy[q]     = cnt[q] != '0;
    assign tail_hit[q] = busy[q] && (te[EW-1 -: RW] == in_s0 || te[EW-1 -: RW] == in_s1);
    assign head_ok[q]  = busy[q] && rdy[head_e[q][RW-1:0]] && rdy[head_e[q][2*RW-1:RW]];

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[q] <= CW'(DEPTH));
    a_r8_refused_not_written: assert property (@(posedge clk) disable iff (!rst_n)
      (in_stall && !pop[q]) |=> cnt[q] == $past(cnt[q]));
    a_r9_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_hold && !(acc && sel_q == QW'(q))) |=> cnt[q] == $past(cnt[q]));
  end

  assign both_rdy = rdy[in_s0] & rdy[in_s1];

  always_comb begin
    emp_ok = 1'b0; emp_q = '0;
    hit_ok = 1'b0; hit_q = '0;
    for (int q = NQ - 1; q >= 0; q--) begin
      if (!busy[q])    begin emp_ok = 1'b1; emp_q = QW'(q); end
      if (tail_hit[q]) begin hit_ok = 1'b1; hit_q = QW'(q); end
    end
    if (!both_rdy && hit_ok) begin sel_ok = 1'b1;   sel_q = hit_q; end
    else                     begin sel_ok = emp_ok; sel_q = emp_q; end
  end

  assign in_stall = in_valid && (!sel_ok || cnt[sel_q] == CW'(DEPTH));
  assign acc      = in_valid && !in_stall;
  assign wp       = hd[sel_q] + PW'(cnt[sel_q]);

  always_comb begin
    int n;
    n        = 0;
    pop      = '0;
    iss_vld  = '0;
    iss_dst  = '0;
    iss_fifo = '0;
    for (int q = 0; q < NQ; q++) begin
      if (head_ok[q] && !iss_hold && n < IW) begin
        pop[q]                = 1'b1;
        iss_vld[n]            = 1'b1;
        iss_dst[n*RW +: RW]   = head_e[q][EW-1 -: RW];
        iss_fifo[n*QW +: QW]  = QW'(q);
        n++;
      end
    end
  end

  always_comb begin
    rdy_nxt = rdy;
    for (int i = 0; i < IW; i++)
      if (iss_vld[i]) rdy_nxt[iss_dst[i*RW +: RW]] = 1'b1;
    if (acc) rdy_nxt[in_dst] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy <= '1;
      for (int q = 0; q < NQ; q++) begin
        hd[q]  <= '0;
        cnt[q] <= '0;
      end
    end else begin
      rdy <= rdy_nxt;
      for (int q = 0; q < NQ; q++) begin
        hd[q]  <= hd[q] + PW'(pop[q]);
        cnt[q] <= cnt[q] + CW'(acc && sel_q == QW'(q)) - CW'(pop[q]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (acc) mem[sel_q][wp] <= {in_dst, in_s1, in_s0};
  end

  a_r7_dispatch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !rdy[$past(in_dst)]);
  a_r7_issue_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld[0] && !(acc && in_dst == iss_dst[RW-1:0])) |=> rdy[$past(iss_dst[RW-1:0])]);
  a_r9_hold_silent: assert property (@(posedge clk) disable iff (!rst_n)
    iss_hold |-> iss_vld == '0);

  for (genvar i = 1; i < IW; i++) begin : g_slot
    a_r6_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
      iss_vld[i] |-> (iss_vld[i-1] && iss_fifo[i*QW +: QW] > iss_fifo[(i-1)*QW +: QW]));
  end
endmodule

// File: tb/dep_fifo_iq_tb.sv
`timescale 1ns/1ps
module dep_fifo_iq_tb;
  localparam int NQ = 4, DEPTH = 8, NREG = 32, IW = 2;
  localparam int RW = $clog2(NREG), QW = $clog2(NQ);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, iss_hold = 1'b0;
  logic [RW-1:0] in_dst = '0, in_s0 = '0, in_s1 = '0;
  logic in_stall;
  logic [IW-1:0] iss_vld;
  logic [IW*RW-1:0] iss_dst;
  logic [IW*QW-1:0] iss_fifo;

  always #2 clk = ~clk;

  dep_fifo_iq #(.NQ(NQ), .DEPTH(DEPTH), .NREG(NREG), .IW(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst(in_dst),
    .in_s0(in_s0), .in_s1(in_s1), .iss_hold(iss_hold), .in_stall(in_stall),
    .iss_vld(iss_vld), .iss_dst(iss_dst), .iss_fifo(iss_fifo));

  int mdst [NQ][DEPTH];
  int ms0  [NQ][DEPTH];
  int ms1  [NQ][DEPTH];
  int mhd  [NQ];
  int mcnt [NQ];
  bit mrdy [NREG];
  int nchk = 0, nbad = 0;

  task automatic chk(input string tg, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tg, what, act, exp);
    end
  endtask

  function automatic int tail_dst(input int q);
    return mdst[q][(mhd[q] + mcnt[q] - 1) % DEPTH];
  endfunction

  function automatic int pick_fifo(input int a, input int b);
    int emp = -1, hit = -1;
    for (int q = NQ - 1; q >= 0; q--) begin
      if (mcnt[q] == 0) emp = q;
      if (mcnt[q] > 0 && (tail_dst(q) == a || tail_dst(q) == b)) hit = q;
    end
    if (mrdy[a] && mrdy[b]) return emp;
    return (hit >= 0) ? hit : emp;
  endfunction

  task automatic step(input string tg, input bit v, input int d, input int a, input int b, input bit h);
    int ev[IW], ed[IW], ef[IW];
    int n = 0, sq, p;
    bit es;
    @(negedge clk);
    in_valid = v; in_dst = RW'(d); in_s0 = RW'(a); in_s1 = RW'(b); iss_hold = h;
    #1;
    for (int i = 0; i < IW; i++) begin ev[i] = 0; ed[i] = 0; ef[i] = 0; end
    for (int q = 0; q < NQ; q++) begin
      if (!h && mcnt[q] > 0 && n < IW && mrdy[ms0[q][mhd[q]]] && mrdy[ms1[q][mhd[q]]]) begin
        ev[n] = 1; ed[n] = mdst[q][mhd[q]]; ef[n] = q; n++;
      end
    end
    sq = pick_fifo(a, b);
    es = v && (sq < 0 || mcnt[sq] == DEPTH);
    chk(tg, "in_stall", int'(in_stall), int'(es));
    for (int i = 0; i < IW; i++) begin
      chk(tg, $sformatf("iss_vld[%0d]", i), int'(iss_vld[i]), ev[i]);
      if (ev[i] != 0 && iss_vld[i]) begin
        chk(tg, $sformatf("iss_dst[%0d]", i), int'(iss_dst[i*RW +: RW]), ed[i]);
        chk(tg, $sformatf("iss_fifo[%0d]", i), int'(iss_fifo[i*QW +: QW]), ef[i]);
      end
    end
    if (v && !es) begin
      p = (mhd[sq] + mcnt[sq]) % DEPTH;
      mdst[sq][p] = d; ms0[sq][p] = a; ms1[sq][p] = b;
      mcnt[sq]++;
    end
    for (int i = 0; i < IW; i++) if (ev[i] != 0) begin
      mhd[ef[i]] = (mhd[ef[i]] + 1) % DEPTH;
      mcnt[ef[i]]--;
      mrdy[ed[i]] = 1'b1;
    end
    if (v && !es) mrdy[d] = 1'b0;
  endtask

  task automatic drain(input string tg);
    for (int k = 0; k < 24; k++) step(tg, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    int last = 1, prev = 2;
    void'($urandom(32'd4242));
    for (int q = 0; q < NQ; q++) begin mhd[q] = 0; mcnt[q] = 0; end
    for (int r = 0; r < NREG; r++) mrdy[r] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: idle after reset; then an all-ready instruction issues at once
    step("R1", 0, 0, 0, 0, 0);
    step("R1", 1, 9, 30, 31, 0);
    step("R1", 0, 0, 0, 0, 0);
    drain("R1");

    // steering corners under hold
    step("R4", 1, 10, 1, 2, 1);    // all ready -> FIFO 0
    step("R2", 1, 11, 10, 3, 1);   // tail of FIFO 0 writes r10
    step("R3", 1, 12, 10, 4, 1);   // r10 no longer a tail -> empty FIFO 1
    step("R4", 1, 13, 5, 6, 1);    // all ready -> FIFO 2
    step("R2", 1, 14, 13, 11, 1);  // tails of FIFO 0 and 2 match -> lowest
    step("R4", 1, 15, 7, 7, 1);    // FIFO 3
    step("R8", 1, 16, 8, 8, 1);    // all ready, no empty FIFO -> refused
    step("R9", 0, 0, 0, 0, 1);
    step("R6", 0, 0, 0, 0, 0);     // ready heads of FIFO 0,2,3: two lowest leave
    step("R5", 0, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 0);
    drain("R5");

    // full FIFO refusal
    step("R4", 1, 20, 1, 2, 1);
    for (int k = 21; k < 28; k++) step("R2", 1, k, k - 1, 3, 1);
    step("R8", 1, 28, 27, 3, 1);   // FIFO 0 holds DEPTH entries
    step("R4", 1, 29, 1, 2, 1);
    step("R6", 0, 0, 0, 0, 0);
    drain("R5");

    // consumer dispatched while its producer issues: waits a cycle
    step("R7", 1, 17, 1, 2, 0);
    step("R7", 1, 18, 17, 2, 0);
    step("R7", 0, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 0);

    for (int k = 0; k < 4000; k++) begin
      bit v = ($urandom % 10) < 7;
      bit h = ($urandom % 10) < 3;
      int d = -1, a, b;
      for (int t = 0; t < 8; t++) begin
        int c = int'($urandom % NREG);
        if (d < 0 && mrdy[c]) d = c;
      end
      if (d < 0) begin v = 0; d = 0; end
      a = ($urandom % 2) ? last : int'($urandom % NREG);
      b = ($urandom % 2) ? prev : int'($urandom % NREG);
      step("RAND(R2,R3,R4,R5,R6,R8)", v, d, a, b, h);
      if (v) begin prev = last; last = d; end
    end
    drain("R5");

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule